// File: doc/BRIEF.md
# Two-Wire Read-Only Register Responder

This block is the target side of a cut-down two-wire serial bus that only supports reads. A bus master opens a transfer with a start condition. It then clocks out a seven-bit target address followed by a direction bit. If the address and direction match, the block answers in the acknowledge slot and takes in an eight-bit register index. It acknowledges that index too. It then shifts out the eight-bit contents of the selected register, most significant bit first. The master closes the transfer with its own acknowledge slot and a stop condition.

The block runs on a system clock that is much faster than SCL. SCL and SDA pass through a synchroniser before the block looks at them. SDA is split into an input, an output value and an output enable, which the chip's pad resolves into a tristate line. There is no data stream at the edge of the block: every pin is a plain control or line pin, so no valid/ready handshake applies. The register bank is read-only, and its contents are loaded with computed constants at reset.

Top module: `twreg_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_oe` is 0, and the block waits for a start condition.
- R2: A start is SDA falling while SCL is high. After a start, the next eight SCL rising edges capture the seven-bit address, most significant bit first, and then the direction bit, where 1 means read.
- R3: When the captured address equals `dev_addr` and the direction bit is 1, the block drives 1 in the ninth (acknowledge) slot.
- R4: On any other address or direction, the block drives 0 in the acknowledge slot. It then takes a resent address on the following eight SCL cycles without waiting for a new start.
- R5: After a matched address, the block captures an eight-bit register index, most significant bit first. If the index is below REG_COUNT (default 16), it drives 1 in the following acknowledge slot.
- R6: If the index is REG_COUNT or higher, the block drives 0 in that acknowledge slot and returns to idle. It then leaves SDA released for all later bits until the next start.
- R7: After an accepted index, the block drives the eight bits of register i, most significant bit first. Register i holds (i*PRESET_MUL + PRESET_ADD) mod 256 from reset, with defaults PRESET_MUL = 29 and PRESET_ADD = 90.
- R8: `sda_oe` and `sda_o` change only while the synchronised SCL is low. They never change across a high phase of SCL, except when a start or stop condition occurs.
- R9: SDA is released (`sda_oe` = 0) whenever the master owns the line: during address bits, index bits, the master's acknowledge slot, and after the transfer ends.
- R10: A stop (SDA rising while SCL is high) returns the block to idle with SDA released. A start at any point restarts address capture, with the bit count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Fixed target address of this block |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved serial data line from the bus |
| sda_o | output | 1 | Value driven onto SDA when enabled |
| sda_oe | output | 1 | SDA drive enable; 0 leaves the line high impedance |

## Verification
The embedded assertions check the following on every cycle: SDA drive is held steady across SCL high phases, drive is enabled only in the block's own slots, a start always re-arms address capture, a stop always idles, and a refused index always drops back to idle. The bench's scenarios are what show the values driven in those slots. These include the acknowledge polarity on matches and mismatches, the preset register contents, MSB-first ordering, and the address resend taken without a new start. They also show that later bits are ignored after a refused index, and that a restart in the middle of an index leaves a clean transfer.

// File: rtl/twreg_pkg.sv
package twreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_REG,
    ST_RACK,
    ST_DATA,
    ST_MACK,
    ST_WAIT
  } tw_state_e;

endpackage

// File: rtl/twreg_line_sync.sv
module twreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_raw;
          sda_chain <= sda_raw;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
          sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
        end
      end
    end
  endgenerate

  assign scl_q = scl_chain[STAGES-1];
  assign sda_q = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/twreg_reg_bank.sv
module twreg_reg_bank #(
  parameter int REG_COUNT  = 16,
  parameter int DATA_W     = 8,
  parameter int PRESET_MUL = 29,
  parameter int PRESET_ADD = 90,
  localparam int IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] bank [REG_COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        bank[i] <= DATA_W'(i * PRESET_MUL + PRESET_ADD);
      end
    end
  end

  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/twreg_slave_fsm.sv
module twreg_slave_fsm
  import twreg_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 16,
  localparam int IDX_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_o,
  output logic              sda_oe
);

  localparam logic [CNT_W-1:0]  BITS_FULL = CNT_W'(DATA_W);
  localparam logic [DATA_W:0]   REG_LIMIT = (DATA_W + 1)'(REG_COUNT);

  tw_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic              addr_ok;
  logic              reg_ok;
  logic              addr_hit;
  logic              idx_hit;

  assign addr_hit = (rx_sh[DATA_W-1 -: ADDR_W] == dev_addr) && rx_sh[0];
  assign idx_hit  = ({1'b0, rx_sh} < REG_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr_ok <= 1'b0;
      reg_ok  <= 1'b0;
      rd_idx  <= '0;
      sda_o   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      rx_sh   <= '0;
      sda_o   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_REG: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], sda_q};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == BITS_FULL) begin
            sda_oe <= 1'b1;
            if (state == ST_ADDR) begin
              state   <= ST_AACK;
              addr_ok <= addr_hit;
              sda_o   <= addr_hit;
            end else begin
              state  <= ST_RACK;
              reg_ok <= idx_hit;
              sda_o  <= idx_hit;
              rd_idx <= rx_sh[IDX_W-1:0];
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= addr_ok ? ST_REG : ST_ADDR;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            if (reg_ok) begin
              state   <= ST_DATA;
              sda_o   <= rd_data[DATA_W-1];
              tx_sh   <= {rd_data[DATA_W-2:0], 1'b0};
              bit_cnt <= CNT_W'(1);
            end else begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (scl_fall) begin
            if (bit_cnt == BITS_FULL) begin
              state  <= ST_MACK;
              sda_oe <= 1'b0;
            end else begin
              sda_o   <= tx_sh[DATA_W-1];
              tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_fall) state <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  // R8: drive value and enable hold across an SCL high phase
  assert_sda_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && !start_det && !stop_det &&
     !$past(start_det) && !$past(stop_det))
    |-> ($stable(sda_oe) && $stable(sda_o)));

  // R9: the line is only driven inside the block's own slots
  assert_release_outside_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {ST_AACK, ST_RACK, ST_DATA}));

  // R10: a start re-arms address capture from bit zero
  assert_start_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && bit_cnt == '0 && !sda_oe));

  // R10: a stop idles the block with the line released
  assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

  // R6: a refused register index ends the transfer
  assert_bad_index_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && !reg_ok && scl_fall && !start_det && !stop_det)
    |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/twreg_slave.sv
module twreg_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int REG_COUNT   = 16,
  parameter int PRESET_MUL  = 29,
  parameter int PRESET_ADD  = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;

  twreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twreg_reg_bank #(
    .REG_COUNT  (REG_COUNT),
    .DATA_W     (DATA_W),
    .PRESET_MUL (PRESET_MUL),
    .PRESET_ADD (PRESET_ADD)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  twreg_slave_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .sda_o     (sda_o),
    .sda_oe    (sda_oe)
  );

endmodule

// File: tb/twreg_slave_bench.sv
module twreg_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 8;
  localparam logic [6:0] MY_ADDR = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic dut_o, dut_oe, line;
  int   checks = 0;
  int   fails = 0;

  assign line = dut_oe ? dut_o : m_sda;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twreg_slave u_twreg_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (MY_ADDR),
    .scl_i    (scl),
    .sda_i    (line),
    .sda_o    (dut_o),
    .sda_oe   (dut_oe)
  );

  function automatic logic [7:0] preset(input int i);
    return 8'((i * 29 + 90) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one SCL period; expectation compared on every clock of the high phase
  task automatic slot(input logic mbit, input logic e_oe, input logic e_o, input string req);
    @(negedge clk) scl = 1'b0;
    repeat (PHASE / 2) @(negedge clk);
    m_sda = e_oe ? 1'b1 : mbit;
    repeat (PHASE / 2) @(negedge clk);
    scl = 1'b1;
    for (int k = 0; k < PHASE; k++) begin
      @(negedge clk);
      check(dut_oe == e_oe, {req, " oe"}, int'(dut_oe), int'(e_oe));
      if (e_oe) check(dut_o == e_o, {req, " value"}, int'(dut_o), int'(e_o));
    end
  endtask

  task automatic bus_start();
    @(negedge clk) scl = 1'b0;
    repeat (PHASE / 2) @(negedge clk);
    m_sda = 1'b1;
    repeat (PHASE / 2) @(negedge clk);
    scl = 1'b1;
    repeat (PHASE / 2) @(negedge clk);
    m_sda = 1'b0;
    repeat (PHASE / 2) @(negedge clk);
  endtask

  task automatic bus_stop();
    @(negedge clk) scl = 1'b0;
    repeat (PHASE / 2) @(negedge clk);
    m_sda = 1'b0;
    repeat (PHASE / 2) @(negedge clk);
    scl = 1'b1;
    repeat (PHASE / 2) @(negedge clk);
    m_sda = 1'b1;
    repeat (PHASE) @(negedge clk);
    check(dut_oe == 1'b0, "R10 released after stop", int'(dut_oe), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, 1'b0, req);
  endtask

  task automatic full_read(input int idx);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, "R2/R9 address");
    slot(1'b1, 1'b1, 1'b1, "R3 address ack");
    send_byte(8'(idx), "R5/R9 index");
    slot(1'b1, 1'b1, 1'b1, "R5 index ack");
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] d;
      d = preset(idx);
      slot(1'b1, 1'b1, d[i], "R7 data");
    end
    slot(1'b1, 1'b0, 1'b0, "R9 master ack");
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dut_oe == 1'b0, "R1 released in reset", int'(dut_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dut_oe == 1'b0, "R1 released after reset", int'(dut_oe), 0);

    full_read(3);

    // R4: wrong address refused, then resent without a new start
    bus_start();
    send_byte({7'h2D, 1'b1}, "R4 wrong address");
    slot(1'b1, 1'b1, 1'b0, "R4 refused ack");
    send_byte({MY_ADDR, 1'b1}, "R4 resent address");
    slot(1'b1, 1'b1, 1'b1, "R4 resend ack");
    send_byte(8'd0, "R5 index");
    slot(1'b1, 1'b1, 1'b1, "R5 index 0 ack");
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] d;
      d = preset(0);
      slot(1'b1, 1'b1, d[i], "R7 data reg0");
    end
    slot(1'b1, 1'b0, 1'b0, "R9 master ack");
    bus_stop();

    // R4: correct address with write direction is refused
    bus_start();
    send_byte({MY_ADDR, 1'b0}, "R4 write direction");
    slot(1'b1, 1'b1, 1'b0, "R4 direction refused");
    bus_stop();

    // R6: index out of range refused, later bits ignored
    bus_start();
    send_byte({MY_ADDR, 1'b1}, "R2 address");
    slot(1'b1, 1'b1, 1'b1, "R3 address ack");
    send_byte(8'd16, "R6 index");
    slot(1'b1, 1'b1, 1'b0, "R6 index refused");
    send_byte(8'hA5, "R6 ignored bits");
    slot(1'b1, 1'b0, 1'b0, "R6 ignored ack slot");
    bus_stop();

    // R10: restart in the middle of an index, then a clean read of the last register
    bus_start();
    send_byte({MY_ADDR, 1'b1}, "R2 address");
    slot(1'b1, 1'b1, 1'b1, "R3 address ack");
    slot(1'b0, 1'b0, 1'b0, "R10 partial index");
    slot(1'b1, 1'b0, 1'b0, "R10 partial index");
    slot(1'b1, 1'b0, 1'b0, "R10 partial index");
    full_read(15);

    // R8/R7: another pattern
    full_read(9);

    finish_run();
  end

endmodule